// File: doc/BRIEF.md
# Packed Lane Compare / Min-Max / Average ALU

This block operates on two 64-bit packed operands split into equal lanes of 8, 16 or 32 bits. Each lane is computed on its own. It can build an equality mask or a greater-than mask, where a lane is all ones when the test holds. It can pick the smaller or the larger lane value, in signed or unsigned order. It can add or subtract with wrap-around inside each lane. It can also take the unsigned mean of two byte or halfword lanes, with a selectable round-up bit.

Each result comes with a 32-bit status word that holds one negative flag and one zero flag per lane. The positions of these flags depend on the lane size. The operands and the operation are captured on a valid strobe. The result and the status word appear one cycle later, and they hold until the next strobe.

Top module: `pkd_lane_alu`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high at the clock edge, and low otherwise. After reset, `result`, `status` and `out_valid` are zero.
- R2: `lane_sel` selects the lane width: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes and 2 gives two 32-bit lanes. Lane i occupies bits i*W through i*W+W-1.
- R3: `op_code` 0 (equal), 1 (signed greater) and 2 (unsigned greater) write all ones into a lane when A's lane satisfies the test against B's lane, and all zeros otherwise.
- R4: `op_code` 3 and 4 return, per lane, the smaller of A and B in signed and unsigned order respectively. Codes 5 and 6 return the larger, in signed and unsigned order respectively.
- R5: `op_code` 7 (A+B) and 8 (A-B) wrap modulo 2^W in each lane, and no carry or borrow passes into the next lane.
- R6: `op_code` 9 returns (A+B+`rnd_up`)>>1 per unsigned lane. The sum is formed with one extra bit, so it cannot overflow.
- R7: Each lane's N flag is the lane's top bit, and its Z flag is set when the whole lane is zero. N sits at status bit S*i+S-1 and Z at bit S*i+S-2, where S is 4, 8 or 16 for 8-, 16- or 32-bit lanes. Every other status bit is zero.
- R8: For `op_code` 9, every N position in `status` is zero and only the Z flags are reported.
- R9: A `lane_sel` of 3, an `op_code` from 10 to 15, or `op_code` 9 with 32-bit lanes gives a zero `result` and a zero `status`.
- R10: While `in_valid` is low, changes on `op_code`, `lane_sel`, `rnd_up`, `opnd_a` and `opnd_b` leave `result` and `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for operands and operation |
| op_code | input | 4 | Operation select (codes 0 to 9) |
| lane_sel | input | 2 | Lane width select |
| rnd_up | input | 1 | Rounding bit for averaging |
| opnd_a | input | 64 | Packed operand A |
| opnd_b | input | 64 | Packed operand B |
| out_valid | output | 1 | Result of the last strobe is present |
| result | output | 64 | Packed lane result |
| status | output | 32 | Per-lane N/Z flag word |

## Verification
The lane result and its flag update always land in the same cycle. A compare that writes an all-ones lane must therefore raise N and clear Z in that same cycle. The stimulus provokes this by issuing back-to-back strobes in which the lane size and the operation change on every cycle, so the layout of the status word shifts from one result to the next. A queue-based scoreboard judges each result by comparing the result and the status word together against an independent per-lane model.

// File: rtl/pkd_alu_pkg.sv
package pkd_alu_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned NUM_SIZES = 3;

  localparam logic [3:0] OPC_CEQ  = 4'd0;
  localparam logic [3:0] OPC_CGTS = 4'd1;
  localparam logic [3:0] OPC_CGTU = 4'd2;
  localparam logic [3:0] OPC_MINS = 4'd3;
  localparam logic [3:0] OPC_MINU = 4'd4;
  localparam logic [3:0] OPC_MAXS = 4'd5;
  localparam logic [3:0] OPC_MAXU = 4'd6;
  localparam logic [3:0] OPC_ADD  = 4'd7;
  localparam logic [3:0] OPC_SUB  = 4'd8;
  localparam logic [3:0] OPC_AVG  = 4'd9;

  localparam logic [1:0] LN_8  = 2'd0;
  localparam logic [1:0] LN_16 = 2'd1;
  localparam logic [1:0] LN_32 = 2'd2;
  localparam logic [1:0] LN_64 = 2'd3;

  // Every status position that a lane size defines (N and Z).
  function automatic logic [STAT_W-1:0] flag_layout(logic [1:0] ln);
    case (ln)
      LN_8:    return 32'hCCCC_CCCC;
      LN_16:   return 32'hC0C0_C0C0;
      LN_32:   return 32'hC000_C000;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // N positions only.
  function automatic logic [STAT_W-1:0] neg_layout(logic [1:0] ln);
    case (ln)
      LN_8:    return 32'h8888_8888;
      LN_16:   return 32'h8080_8080;
      LN_32:   return 32'h8000_8000;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic bytes_are_masks(logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DATA_W/8; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/pkd_status_pack.sv
module pkd_status_pack #(
  parameter int unsigned NL     = 8,
  parameter int unsigned STAT_W = 32
) (
  input  logic [NL-1:0]     neg_f,
  input  logic [NL-1:0]     zero_f,
  output logic [STAT_W-1:0] stat
);
  localparam int unsigned STRIDE = STAT_W / NL;

  for (genvar i = 0; i < NL; i++) begin : g_slot
    if (STRIDE > 2) begin : g_pad
      assign stat[i*STRIDE +: STRIDE] = {neg_f[i], zero_f[i], {(STRIDE-2){1'b0}}};
    end else begin : g_tight
      assign stat[i*STRIDE +: STRIDE] = {neg_f[i], zero_f[i]};
    end
  end
endmodule

// File: rtl/pkd_lane_slice.sv
module pkd_lane_slice
  import pkd_alu_pkg::*;
#(
  parameter int unsigned DW = 64,
  parameter int unsigned LW = 8,
  parameter int unsigned SW = 32
) (
  input  logic [3:0]    op,
  input  logic          rnd,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic [SW-1:0] stat
);
  localparam int unsigned NL = DW / LW;

  function automatic logic [LW-1:0] lane_fn(logic [3:0] f, logic r,
                                            logic [LW-1:0] x, logic [LW-1:0] y);
    logic [LW:0] sum;
    logic        gts, gtu;
    gts = $signed(x) > $signed(y);
    gtu = x > y;
    sum = {1'b0, x} + {1'b0, y} + {{LW{1'b0}}, r};
    case (f)
      OPC_CEQ:  return (x == y) ? '1 : '0;
      OPC_CGTS: return gts ? '1 : '0;
      OPC_CGTU: return gtu ? '1 : '0;
      OPC_MINS: return gts ? y : x;
      OPC_MINU: return gtu ? y : x;
      OPC_MAXS: return gts ? x : y;
      OPC_MAXU: return gtu ? x : y;
      OPC_ADD:  return x + y;
      OPC_SUB:  return x - y;
      OPC_AVG:  return sum[LW:1];
      default:  return '0;
    endcase
  endfunction

  logic [NL-1:0] neg_f, zero_f;
  logic          is_avg;
  assign is_avg = (op == OPC_AVG);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign res[i*LW +: LW] = lane_fn(op, rnd, a[i*LW +: LW], b[i*LW +: LW]);
    assign neg_f[i]  = res[i*LW + LW - 1] & ~is_avg;
    assign zero_f[i] = ~|res[i*LW +: LW];
  end

  pkd_status_pack #(.NL(NL), .STAT_W(SW)) u_pack (
    .neg_f (neg_f),
    .zero_f(zero_f),
    .stat  (stat)
  );
endmodule

// File: rtl/pkd_lane_alu.sv
module pkd_lane_alu
  import pkd_alu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [3:0]  op_code,
  input  logic [1:0]  lane_sel,
  input  logic        rnd_up,
  input  logic [63:0] opnd_a,
  input  logic [63:0] opnd_b,
  output logic        out_valid,
  output logic [63:0] result,
  output logic [31:0] status
);
  logic [3:0]        op_q;
  logic [1:0]        lane_q;
  logic              rnd_q;
  logic [DATA_W-1:0] a_q, b_q;
  logic              vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= 4'hF;
      lane_q <= LN_64;
      rnd_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        op_q   <= op_code;
        lane_q <= lane_sel;
        rnd_q  <= rnd_up;
        a_q    <= opnd_a;
        b_q    <= opnd_b;
      end
    end
  end

  logic [DATA_W-1:0] res_w  [NUM_SIZES];
  logic [STAT_W-1:0] stat_w [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    pkd_lane_slice #(.DW(DATA_W), .LW(8 << g), .SW(STAT_W)) u_slice (
      .op  (op_q),
      .rnd (rnd_q),
      .a   (a_q),
      .b   (b_q),
      .res (res_w[g]),
      .stat(stat_w[g])
    );
  end

  // Illegal combination: 64-bit lanes, undefined opcode, or 32-bit averaging.
  logic op_bad;
  assign op_bad = (lane_q == LN_64) || (op_q > OPC_AVG) ||
                  ((op_q == OPC_AVG) && (lane_q == LN_32));

  always_comb begin
    result = '0;
    status = '0;
    if (!op_bad) begin
      case (lane_q)
        LN_8:    begin result = res_w[0]; status = stat_w[0]; end
        LN_16:   begin result = res_w[1]; status = stat_w[1]; end
        LN_32:   begin result = res_w[2]; status = stat_w[2]; end
        default: begin result = '0;       status = '0;        end
      endcase
    end
  end

  assign out_valid = vld_q;

  // ---------------- assertions ----------------
  p_strobe_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_cmp_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lane_q == LN_8 && op_q <= OPC_CGTU) |-> bytes_are_masks(result));
  p_undef_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((status & ~flag_layout(lane_q)) == '0));
  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lane_q == LN_32 && !op_bad) |-> (status[14] == (result[31:0] == '0)));
  p_avg_no_n_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == OPC_AVG) |-> ((status & neg_layout(lane_q)) == '0));
  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && lane_q == LN_64) |-> (result == '0 && status == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(status)));
endmodule

// File: tb/pkd_lane_alu_tb.sv
module pkd_lane_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [1:0]  lane_sel = '0;
  logic        rnd_up = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [31:0] status;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  pkd_lane_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .lane_sel(lane_sel), .rnd_up(rnd_up), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .result(result), .status(status)
  );

  typedef struct {
    logic [63:0] res;
    logic [31:0] st;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // Independent per-lane model built from the requirements.
  function automatic void model(input logic [3:0] op, input logic [1:0] ln,
                                input logic r, input logic [63:0] a, input logic [63:0] b,
                                output logic [63:0] res, output logic [31:0] st);
    int lw, nl, stride;
    longint unsigned m, x, y, o;
    longint sx, sy;
    res = '0; st = '0;
    if (ln == 2'd3 || op > 4'd9 || (op == 4'd9 && ln == 2'd2)) return;   // R9
    lw = 8 << ln; nl = 64 / lw; stride = 32 / nl;
    m = (64'd1 << lw) - 1;
    for (int i = 0; i < nl; i++) begin
      x = (a >> (i*lw)) & m;
      y = (b >> (i*lw)) & m;
      sx = ((x >> (lw-1)) & 1) != 0 ? longint'(x) - longint'(64'd1 << lw) : longint'(x);
      sy = ((y >> (lw-1)) & 1) != 0 ? longint'(y) - longint'(64'd1 << lw) : longint'(y);
      case (op)
        4'd0: o = (x == y) ? m : 0;
        4'd1: o = (sx > sy) ? m : 0;
        4'd2: o = (x > y) ? m : 0;
        4'd3: o = (sx < sy) ? x : y;
        4'd4: o = (x < y) ? x : y;
        4'd5: o = (sx > sy) ? x : y;
        4'd6: o = (x > y) ? x : y;
        4'd7: o = (x + y) & m;
        4'd8: o = (x - y) & m;
        default: o = (x + y + longint'(r)) >> 1;
      endcase
      res |= o << (i*lw);
      if (op != 4'd9 && ((o >> (lw-1)) & 1) != 0) st[stride*i + stride - 1] = 1'b1;
      if (o == 0) st[stride*i + stride - 2] = 1'b1;
    end
  endfunction

  task automatic push(input logic [3:0] op, input logic [1:0] ln, input logic r,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op_code = op; lane_sel = ln; rnd_up = r; opnd_a = a; opnd_b = b;
    model(op, ln, r, a, b, e.res, e.st);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per output cycle.
  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R1 unexpected out_valid", {95'd0, out_valid}, 96'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(result == e.res && status == e.st, e.tag, {result, status}, {e.res, e.st});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held_r;
    logic [31:0] held_s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && result == 0 && status == 0, "R1 reset state",
        {result, status}, 96'd0);

    // R3 compares, byte lanes with equal/unequal and sign corner
    push(4'd0, 2'd0, 0, 64'h1122_3344_5566_7788, 64'h1122_0044_5500_7788, "R3 cmpeq 8");
    push(4'd1, 2'd0, 0, 64'h8000_7F01_FF00_0102, 64'h7F80_807F_0000_0201, "R3 cmpgt signed 8");
    push(4'd2, 2'd0, 0, 64'h8000_7F01_FF00_0102, 64'h7F80_807F_0000_0201, "R3 cmpgt unsigned 8");
    push(4'd1, 2'd1, 0, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0000_0000, "R2 R3 cmpgt signed 16");
    push(4'd0, 2'd2, 0, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0000, "R2 R3 cmpeq 32");
    // R4 min/max
    push(4'd3, 2'd0, 0, 64'h80FF_7F01_1020_3040, 64'h7F01_80FF_2010_4030, "R4 min signed 8");
    push(4'd4, 2'd0, 0, 64'h80FF_7F01_1020_3040, 64'h7F01_80FF_2010_4030, "R4 min unsigned 8");
    push(4'd5, 2'd1, 0, 64'h8000_7FFF_1234_FFFE, 64'h7FFF_8000_1235_0001, "R4 max signed 16");
    push(4'd6, 2'd2, 0, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, "R4 max unsigned 32");
    // R5 wrap with no inter-lane carry
    push(4'd7, 2'd0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, "R5 add wrap 8");
    push(4'd8, 2'd1, 0, 64'h0000_0001_8000_0000, 64'h0001_0001_0001_0000, "R5 sub borrow 16");
    push(4'd7, 2'd2, 0, 64'hFFFF_FFFF_8000_0000, 64'h0000_0001_8000_0000, "R5 add wrap 32");
    // R6 / R8 average, extra sum bit and rounding
    push(4'd9, 2'd0, 0, 64'hFFFF_0001_0000_8003, 64'hFFFF_0000_0000_7F04, "R6 R8 avg 8 r0");
    push(4'd9, 2'd0, 1, 64'hFFFF_0001_0000_8003, 64'hFFFF_0000_0000_7F04, "R6 R8 avg 8 r1");
    push(4'd9, 2'd1, 1, 64'hFFFF_0000_8000_0003, 64'hFFFF_0000_8000_0004, "R6 R8 avg 16 r1");
    // R9 illegal combinations
    push(4'd7, 2'd3, 0, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, "R9 lane 64");
    push(4'd9, 2'd2, 1, 64'h1234_5678_9ABC_DEF0, 64'h1111_1111_1111_1111, "R9 avg on 32");
    push(4'd12, 2'd0, 0, 64'h1234_5678_9ABC_DEF0, 64'h0, "R9 undefined op");
    idle(3);

    // R7: back-to-back strobes, lane size and op changing every cycle
    for (int k = 0; k < 300; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (k % 5 == 0) ? ra : {$urandom, $urandom};
      push(4'($urandom_range(0, 9)), 2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
           ra, rb, "R7 random status layout");
    end
    idle(3);
    chk(sb_q.size() == 0 && out_valid == 0, "R1 scoreboard drained", {64'd0, 32'(sb_q.size())}, 96'd0);

    // R10: inputs move without a strobe; outputs must hold
    push(4'd7, 2'd1, 0, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040, "R10 setup");
    idle(2);
    held_r = result; held_s = status;
    @(negedge clk);
    op_code = 4'd0; lane_sel = 2'd0; opnd_a = '1; opnd_b = '0; rnd_up = 1'b1;
    repeat (3) @(negedge clk);
    chk(result == held_r && status == held_s && out_valid == 0, "R10 hold without strobe",
        {result, status}, {held_r, held_s});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule